// File: doc/BRIEF.md
# Unlock-Sequence Write Guard

This block sits in front of the write port of a byte-wide nonvolatile memory and decides, for each write strobe, whether the write may reach the array. It watches every write event (a valid strobe with a 17-bit address and an 8-bit data byte) and follows a three-write unlock code. It also holds a protection flag. While the flag is clear, every write goes through. Once the flag is set, a data write goes through only when the full unlock code comes directly before it.

The flag is set by use, not by the code alone. The three code writes followed by one data write arm protection, and that data write is itself allowed. The flag then stays set until the synchronous reset clears it. The reset stands in for the memory's default state at power-up. The permit output is combinational. It is high in the same cycle as the write strobe it qualifies.

Top module: `wp_unlock_guard`

## Requirements
- R1: While rst_n is low at a rising clock edge, the protection flag clears and the sequence tracker returns to idle. After reset, prot_en reads 0.
- R2: wr_permit is never high in a cycle where wr_valid is low.
- R3: The first code write is data 0xAA to address 0x05555. Any other first write leaves the tracker idle.
- R4: The second code write is data 0x55 to address 0x02AAA or to address 0x0AAAA. Both addresses are accepted.
- R5: The third code write is data 0xA0 to address 0x05555. After it, the tracker is armed.
- R6: The three code writes alone leave prot_en at 0. The next write event after the armed state is the data write: it is permitted, and prot_en reads 1 from the following cycle.
- R7: While protection is set, a data write is permitted only if it directly follows a complete code. The write after that one is blocked again.
- R8: A write that does not match the expected code step sends the tracker back to idle. The write is not taken as a new first step. It is blocked when protection is set and permitted when protection is clear.
- R9: While protection is clear, every write is permitted, the code writes included.
- R10: While protection is set, the code writes themselves are not permitted.
- R11: Once set, prot_en stays 1 through any writes until rst_n is low at a clock edge.
- R12: Cycles with wr_valid low do not change the tracker. Idle cycles may appear between code writes without breaking the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write event strobe, one cycle per write |
| wr_addr | input | 17 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| wr_permit | output | 1 | High when this write may reach the array |
| prot_en | output | 1 | Protection flag |

## Verification
The assertions assume that each write event lasts exactly one cycle with wr_valid high. They also assume that address and data are only meaningful while wr_valid is high, so the tracker sees each event exactly once. The bench drives every event as a single-cycle strobe, changes inputs on the falling clock edge, and drops wr_valid between events. It leaves address and data at non-code values while wr_valid is low. Idle gaps are inserted only where R12 is being exercised.

// File: rtl/wp_unlock_pkg.sv
// Package: shared types for the unlock-sequence write guard.
// Assumes: the tracker needs exactly four states (idle, three code steps seen).
package wp_unlock_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_STEP1 = 2'd1,
        TRK_STEP2 = 2'd2,
        TRK_ARMED = 2'd3
    } trk_state_t;

    typedef struct packed {
        logic first;
        logic second;
        logic third;
    } step_hit_t;

endpackage

// File: rtl/wp_step_match.sv
// Module: wp_step_match
// Compares one write event against each of the three unlock code steps.
// Assumes: purely combinational; the caller qualifies the result with the
// write strobe. The second step accepts any of N_ALT addresses.
module wp_step_match
    import wp_unlock_pkg::*;
#(
    parameter int                ADDR_W = 17,
    parameter int                DATA_W = 8,
    parameter int                N_ALT  = 2,
    parameter logic [ADDR_W-1:0] KEY_ADDR_MAIN = 17'h05555,
    parameter logic [N_ALT*ADDR_W-1:0] KEY_ADDR_ALT = {17'h0AAAA, 17'h02AAA},
    parameter logic [DATA_W-1:0] KEY_DATA_1 = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_DATA_2 = 8'h55,
    parameter logic [DATA_W-1:0] KEY_DATA_3 = 8'hA0
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output step_hit_t         hit
);

    logic [N_ALT-1:0] alt_match;
    logic             main_addr_ok;

    // One comparator for each accepted second-step address.
    generate
        for (genvar g = 0; g < N_ALT; g++) begin : g_alt
            assign alt_match[g] = (wr_addr == KEY_ADDR_ALT[g*ADDR_W +: ADDR_W]);
        end
    endgenerate

    assign main_addr_ok = (wr_addr == KEY_ADDR_MAIN);

    // Combine the address and data compares into the step hits.
    always_comb begin
        hit.first  = main_addr_ok && (wr_data == KEY_DATA_1);
        hit.second = (|alt_match) && (wr_data == KEY_DATA_2);
        hit.third  = main_addr_ok && (wr_data == KEY_DATA_3);
    end

endmodule

// File: rtl/wp_seq_track.sv
// Module: wp_seq_track
// Follows the unlock code one write at a time. A mismatch returns it to idle.
// The armed state lasts only until the next write event.
// Assumes: each write event is a single cycle with wr_valid high.
module wp_seq_track
    import wp_unlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  step_hit_t  hit,
    output trk_state_t state
);

    trk_state_t state_nx;

    // Next-state choice for one write event.
    always_comb begin
        state_nx = state;
        if (wr_valid) begin
            unique case (state)
                TRK_IDLE:  state_nx = hit.first  ? TRK_STEP1 : TRK_IDLE;
                TRK_STEP1: state_nx = hit.second ? TRK_STEP2 : TRK_IDLE;
                TRK_STEP2: state_nx = hit.third  ? TRK_ARMED : TRK_IDLE;
                TRK_ARMED: state_nx = TRK_IDLE;
                default:   state_nx = TRK_IDLE;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TRK_IDLE;
        else        state <= state_nx;
    end

    // R12: cycles without a write leave the tracker where it was.
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(state));

    // R8: a write that misses the expected step lands in idle.
    p_miss_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && state == TRK_STEP1 && !hit.second) |=> state == TRK_IDLE);

    // R5: the armed state is reached only through a third-step hit.
    p_armed_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == TRK_ARMED) |-> $past(hit.third && wr_valid));

endmodule

// File: rtl/wp_prot_guard.sv
// Module: wp_prot_guard
// Holds the protection flag and forms the permit for each write.
// Assumes: the tracker state is registered and updates on the same edge.
module wp_prot_guard
    import wp_unlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  trk_state_t state,
    output logic       wr_permit,
    output logic       prot_en
);

    logic armed_write;

    assign armed_write = wr_valid && (state == TRK_ARMED);

    // Permit: open while unprotected, otherwise only the armed data write.
    always_comb begin
        wr_permit = wr_valid && (!prot_en || (state == TRK_ARMED));
    end

    // Sticky protection flag; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)           prot_en <= 1'b0;
        else if (armed_write) prot_en <= 1'b1;
    end

    // R11: the flag never falls without reset.
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prot_en |=> prot_en);

    // R6: the flag rises only after a write in the armed state.
    p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_en) |-> $past(wr_valid && state == TRK_ARMED));

endmodule

// File: rtl/wp_unlock_guard.sv
// Module: wp_unlock_guard (top)
// Guards a memory write port with a three-write unlock code and a sticky
// protection flag. The permit is combinational, in the same cycle as the strobe.
// Assumes: one write event per cycle at most; synchronous active-low reset.
module wp_unlock_guard
    import wp_unlock_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_permit,
    output logic              prot_en
);

    localparam int N_ALT = 2;
    localparam logic [ADDR_W-1:0] KEY_MAIN = ADDR_W'(17'h05555);
    localparam logic [N_ALT*ADDR_W-1:0] KEY_ALT =
        {ADDR_W'(17'h0AAAA), ADDR_W'(17'h02AAA)};

    step_hit_t  hit;
    trk_state_t state;

    wp_step_match #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .N_ALT         (N_ALT),
        .KEY_ADDR_MAIN (KEY_MAIN),
        .KEY_ADDR_ALT  (KEY_ALT),
        .KEY_DATA_1    (DATA_W'(8'hAA)),
        .KEY_DATA_2    (DATA_W'(8'h55)),
        .KEY_DATA_3    (DATA_W'(8'hA0))
    ) u_match (
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit     (hit)
    );

    wp_seq_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .hit      (hit),
        .state    (state)
    );

    wp_prot_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .state     (state),
        .wr_permit (wr_permit),
        .prot_en   (prot_en)
    );

    // R2: no permit without a strobe.
    p_permit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> wr_valid);

    // R9: all writes pass while unprotected.
    p_open_permit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_en && wr_valid) |-> wr_permit);

    // R7 and R10: protected writes outside the armed state are blocked.
    p_blocked_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && wr_valid && state != TRK_ARMED) |-> !wr_permit);

    // R1: reset leaves the flag clear.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !prot_en);

endmodule

// File: tb/wp_unlock_guard_tb.sv
// Directed bench for wp_unlock_guard: one task per scenario.
module wp_unlock_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = 17'h00000;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_permit;
    logic        prot_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wp_unlock_guard dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_permit (wr_permit),
        .prot_en   (prot_en)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // One write event: driven at the falling edge, permit sampled mid-cycle.
    task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic exp, input string req);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #2;
        check(req, $sformatf("permit addr %h data %h", a, d), wr_permit, exp);
        @(negedge clk);
        wr_valid = 1'b0; wr_addr = 17'h01234; wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic code(input logic [16:0] second_addr, input logic exp, input string req);
        wr(17'h05555, 8'hAA, exp, req);
        wr(second_addr, 8'h55, exp, req);
        wr(17'h05555, 8'hA0, exp, req);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        #2;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "prot_en after reset", prot_en, 1'b0);
        check("R2", "permit with no strobe", wr_permit, 1'b0);
    endtask

    task automatic t_open();
        wr(17'h00010, 8'h3C, 1'b1, "R9");
        wr(17'h1FFFF, 8'hFF, 1'b1, "R9");
        wr(17'h05555, 8'hAA, 1'b1, "R9");
        wr(17'h00020, 8'h11, 1'b1, "R8 unprotected miss permitted");
        check("R9", "prot_en still clear", prot_en, 1'b0);
    endtask

    task automatic t_arm();
        code(17'h02AAA, 1'b1, "R9 code bytes open");
        idle(3);
        check("R6", "code alone leaves prot_en clear", prot_en, 1'b0);
        wr(17'h00100, 8'h5A, 1'b1, "R6 data write after code");
        check("R6", "prot_en set after data write", prot_en, 1'b1);
    endtask

    task automatic t_protected();
        wr(17'h00100, 8'h77, 1'b0, "R7 bare write blocked");
        code(17'h02AAA, 1'b0, "R10 code bytes blocked");
        wr(17'h00101, 8'h78, 1'b1, "R4 R7 data after code with 2AAA");
        wr(17'h00102, 8'h79, 1'b0, "R7 second data blocked");
        code(17'h0AAAA, 1'b0, "R10");
        wr(17'h00103, 8'h7A, 1'b1, "R4 data after code with AAAA");
    endtask

    task automatic t_miss();
        wr(17'h05554, 8'hAA, 1'b0, "R3");
        wr(17'h02AAA, 8'h55, 1'b0, "R3");
        wr(17'h05555, 8'hA0, 1'b0, "R3");
        wr(17'h00200, 8'h01, 1'b0, "R3 wrong first address");
        wr(17'h05555, 8'hAB, 1'b0, "R3");
        wr(17'h02AAA, 8'h55, 1'b0, "R3");
        wr(17'h05555, 8'hA0, 1'b0, "R3");
        wr(17'h00200, 8'h02, 1'b0, "R3 wrong first data");
        wr(17'h05555, 8'hAA, 1'b0, "R8");
        wr(17'h01234, 8'h55, 1'b0, "R8 wrong second address");
        wr(17'h05555, 8'hA0, 1'b0, "R8");
        wr(17'h00200, 8'h03, 1'b0, "R8 data after broken code");
        wr(17'h05555, 8'hAA, 1'b0, "R5");
        wr(17'h0AAAA, 8'h55, 1'b0, "R5");
        wr(17'h05555, 8'hA1, 1'b0, "R5");
        wr(17'h00200, 8'h04, 1'b0, "R5 wrong third data");
        wr(17'h05555, 8'hAA, 1'b0, "R8");
        wr(17'h05555, 8'hAA, 1'b0, "R8");
        wr(17'h02AAA, 8'h55, 1'b0, "R8");
        wr(17'h05555, 8'hA0, 1'b0, "R8");
        wr(17'h00200, 8'h05, 1'b0, "R8 repeated first step is not a restart");
    endtask

    task automatic t_gaps();
        wr(17'h05555, 8'hAA, 1'b0, "R12");
        idle(4);
        wr(17'h02AAA, 8'h55, 1'b0, "R12");
        idle(2);
        wr(17'h05555, 8'hA0, 1'b0, "R12");
        idle(5);
        wr(17'h00300, 8'h99, 1'b1, "R12 code with gaps still unlocks");
    endtask

    task automatic t_sticky();
        for (int i = 0; i < 6; i++) wr(17'(i * 3), 8'(i), 1'b0, "R11");
        idle(10);
        check("R11", "prot_en holds", prot_en, 1'b1);
        do_reset();
        check("R11", "reset clears prot_en", prot_en, 1'b0);
        wr(17'h00400, 8'h42, 1'b1, "R1 open after reset");
    endtask

    initial begin
        idle(1);
        t_reset();
        t_open();
        t_arm();
        t_protected();
        t_miss();
        t_gaps();
        t_sticky();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule